// File: doc/BRIEF.md
# Programmable Galois Sequence Generator

This block produces pseudo-random bit sequences and running CRC remainders. It does both with a modular (Galois-form) linear feedback shift register of up to `W` bits. A host writes a tap word, a starting state and a compare limit through a plain address/data/strobe port, then sets a run bit. While running, the register takes one step per clock. Each step shifts toward the MSB and folds the outgoing top bit, XORed with a serial data input, back into the tapped positions.

The taps are given in modular form. Bit j of the tap word stands for tap j+1, and the highest set bit fixes the active register length. A tap word can only change while the block is stopped. The block outputs the parallel state, the serial top bit, and a compare flag that is high while the state is at or above the limit. The only interrupt is a one-cycle pulse when that flag rises.

Top module: `galois_seqgen`

## Requirements
- R1: After a synchronous reset the state is 0, the block is stopped, the tap word is 0, the limit is all ones, and ser_o, cmp_o and irq_o are 0.
- R2: A write is taken on the clock edge where wr_en is high. Address 0 is control (bit 0 = run), address 1 is the tap word, address 2 loads the state, and address 3 is the compare limit.
- R3: Bit j of the tap word is tap j+1. The active length L is the index of the highest set bit plus one. With a zero tap word, a running block holds its state.
- R4: On each edge while running with L>0, fb = state[L-1] XOR din. The next state is (state shifted left by one, masked to L bits) XOR (fb ? ((taps<<1)|1) masked to L bits : 0). State bits at position L and above become 0.
- R5: Tap word 0x55 (modular taps 7,5,3,1) returns to a non-zero start after exactly 127 steps, and tap word 0x05 returns after exactly 7 steps.
- R6: A tap-word write on an edge where the block is running is ignored.
- R7: A state write while stopped sets the state on that edge. A state write while running is ignored and the step proceeds.
- R8: While stopped and with no state write, the state holds.
- R9: A running zero state with din = 0 stays zero.
- R10: ser_o equals state[L-1] of the current state and tap word, and is 0 when the tap word is zero.
- R11: cmp_o equals (state >= limit) for the current state and limit, including in the cycle right after either changes.
- R12: irq_o is high for exactly the cycle in which cmp_o goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | W | Write data |
| din | input | 1 | Serial data folded into the feedback |
| state_o | output | W | Parallel register state |
| ser_o | output | 1 | Top bit of the active register length |
| cmp_o | output | 1 | State is at or above the compare limit |
| irq_o | output | 1 | One-cycle pulse when cmp_o rises |

## Verification
The bench builds the block with its default `W` of 8. This allows a 7-bit maximal-length run of 127 steps and a short 3-bit run of 7 steps. The full 8-bit width also leaves room to load a state with bits above the active length and to watch them clear on the first step. A limit inside the 7-bit range makes the compare flag toggle many times during one period, which exercises both edges of the interrupt pulse.

// File: rtl/galois_seqgen_pkg.sv
package galois_seqgen_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 2'd0,
    RA_TAPS  = 2'd1,
    RA_SEED  = 2'd2,
    RA_LIMIT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/lfsr_regs.sv
module lfsr_regs
  import galois_seqgen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              run_q,
  output logic              run_d,
  output logic [W-1:0]      taps_q,
  output logic [W-1:0]      taps_d,
  output logic [W-1:0]      limit_q,
  output logic [W-1:0]      limit_d,
  output logic              seed_ld
);
  always_comb begin
    run_d   = run_q;
    taps_d  = taps_q;
    limit_d = limit_q;
    seed_ld = 1'b0;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_CTRL:  run_d = wr_data[0];
        RA_TAPS:  if (!run_q) taps_d = wr_data;
        RA_SEED:  seed_ld = !run_q;
        RA_LIMIT: limit_d = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      taps_q  <= '0;
      limit_q <= '1;
    end else begin
      run_q   <= run_d;
      taps_q  <= taps_d;
      limit_q <= limit_d;
    end
  end
endmodule

// File: rtl/lfsr_tapdec.sv
module lfsr_tapdec #(
  parameter int W  = 8,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  taps,
  input  logic [W-1:0]  val,
  output logic [LW-1:0] len,
  output logic [W-1:0]  mask,
  output logic          top
);
  always_comb begin
    len = '0;
    for (int i = 0; i < W; i++) begin
      if (taps[i]) len = LW'(i + 1);
    end
  end

  always_comb begin
    top = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (LW'(i + 1) == len) top = val[i];
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (LW'(g) < len);
  end
endmodule

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int W  = 8,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  taps,
  input  logic          din,
  input  logic          run,
  output logic [W-1:0]  nxt,
  output logic [LW-1:0] len
);
  logic [W-1:0] mask;
  logic         top;
  logic         fb;
  logic [W-1:0] shifted;
  logic [W-1:0] fold;

  lfsr_tapdec #(.W(W), .LW(LW)) u_dec (
    .taps (taps),
    .val  (cur),
    .len  (len),
    .mask (mask),
    .top  (top)
  );

  assign fb      = top ^ din;
  assign shifted = {cur[W-2:0], 1'b0} & mask;
  assign fold    = {taps[W-2:0], 1'b1} & mask;

  always_comb begin
    if (run && (len != '0)) nxt = shifted ^ ({W{fb}} & fold);
    else                    nxt = cur;
  end
endmodule

// File: rtl/lfsr_cmp.sv
module lfsr_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] state_d,
  input  logic [W-1:0] limit_d,
  output logic         cmp_o,
  output logic         irq_o
);
  logic hit;

  assign hit = (state_d >= limit_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      cmp_o <= hit;
      irq_o <= hit && !cmp_o;
    end
  end
endmodule

// File: rtl/galois_seqgen.sv
module galois_seqgen
  import galois_seqgen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              din,
  output logic [W-1:0]      state_o,
  output logic              ser_o,
  output logic              cmp_o,
  output logic              irq_o
);
  localparam int LW = $clog2(W + 1);

  logic          run_q, run_d, seed_ld;
  logic [W-1:0]  taps_q, taps_d, limit_q, limit_d;
  logic [W-1:0]  step_nxt, state_d;
  logic [LW-1:0] cur_len, nxt_len;
  logic [W-1:0]  nxt_mask;
  logic          nxt_top;

  lfsr_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .run_q   (run_q),
    .run_d   (run_d),
    .taps_q  (taps_q),
    .taps_d  (taps_d),
    .limit_q (limit_q),
    .limit_d (limit_d),
    .seed_ld (seed_ld)
  );

  lfsr_step #(.W(W), .LW(LW)) u_step (
    .cur  (state_o),
    .taps (taps_q),
    .din  (din),
    .run  (run_q),
    .nxt  (step_nxt),
    .len  (cur_len)
  );

  assign state_d = seed_ld ? wr_data : step_nxt;

  lfsr_tapdec #(.W(W), .LW(LW)) u_serdec (
    .taps (taps_d),
    .val  (state_d),
    .len  (nxt_len),
    .mask (nxt_mask),
    .top  (nxt_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= '0;
      ser_o   <= 1'b0;
    end else begin
      state_o <= state_d;
      ser_o   <= nxt_top;
    end
  end

  lfsr_cmp #(.W(W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .limit_d (limit_d),
    .cmp_o   (cmp_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/galois_seqgen_chk.sv
module galois_seqgen_chk
  import galois_seqgen_pkg::*;
#(
  parameter int W  = 8,
  parameter int LW = $clog2(W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [W-1:0]      taps,
  input logic [W-1:0]      limit,
  input logic [W-1:0]      state,
  input logic              din,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cmp,
  input logic              irq,
  input logic [LW-1:0]     len
);
  a_r6_taps_frozen: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(taps));

  a_r8_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && wr_addr == RA_SEED)) |=> $stable(state));

  a_r9_zero_stays: assert property (@(posedge clk) disable iff (rst)
    (run && state == '0 && !din) |=> (state == '0));

  a_r4_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (run && len != '0) |=> ((state >> len) == '0));

  a_r11_cmp_level: assert property (@(posedge clk) disable iff (rst)
    cmp == (state >= limit));

  a_r12_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cmp && !$past(cmp)));

  a_r12_rise_gives_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp) |-> irq);
endmodule

bind galois_seqgen galois_seqgen_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run_q),
  .taps    (taps_q),
  .limit   (limit_q),
  .state   (state_o),
  .din     (din),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .cmp     (cmp_o),
  .irq     (irq_o),
  .len     (cur_len)
);

// File: tb/test_galois_seqgen.sv
module test_galois_seqgen;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 50000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         din = 1'b0;
  logic [W-1:0] state_o;
  logic         ser_o, cmp_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model of the register view
  logic         m_run = 1'b0;
  logic [W-1:0] m_taps = '0;
  logic [W-1:0] m_limit = '1;
  logic [W-1:0] m_state = '0;
  logic         m_cmp = 1'b0;
  logic         m_irq = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  galois_seqgen #(.W(W)) i_galois_seqgen (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .din     (din),
    .state_o (state_o),
    .ser_o   (ser_o),
    .cmp_o   (cmp_o),
    .irq_o   (irq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int tap_len(input logic [W-1:0] t);
    int l = 0;
    for (int i = 0; i < W; i++) if (t[i]) l = i + 1;
    return l;
  endfunction

  function automatic logic [W-1:0] mstep(input logic [W-1:0] s, input logic [W-1:0] t, input logic di);
    int l = tap_len(t);
    logic [W:0] m;
    logic fb;
    if (l == 0) return s;
    m  = (9'd1 << l) - 9'd1;
    fb = s[l-1] ^ di;
    return W'(((s << 1) & m[W-1:0]) ^ (fb ? ((({1'b0, t} << 1) | 9'd1) & m) : 9'd0));
  endfunction

  function automatic logic mser(input logic [W-1:0] s, input logic [W-1:0] t);
    int l = tap_len(t);
    return (l == 0) ? 1'b0 : s[l-1];
  endfunction

  task automatic cycle(input logic we, input logic [1:0] a, input logic [W-1:0] d,
                       input logic di, input string req);
    logic old_run;
    logic prev;
    wr_en = we; wr_addr = a; wr_data = d; din = di;
    @(posedge clk);
    #1;
    old_run = m_run;
    if (m_run) m_state = mstep(m_state, m_taps, di);
    if (we) begin
      case (a)
        2'd0: m_run = d[0];
        2'd1: if (!old_run) m_taps = d;
        2'd2: if (!old_run) m_state = d;
        default: m_limit = d;
      endcase
    end
    prev  = m_cmp;
    m_cmp = (m_state >= m_limit);
    m_irq = m_cmp && !prev;
    wr_en = 1'b0; din = 1'b0;
    chk(req, "state", int'(state_o), int'(m_state));
    chk("R10", "ser", int'(ser_o), int'(mser(m_state, m_taps)));
    chk("R11", "cmp", int'(cmp_o), int'(m_cmp));
    chk("R12", "irq", int'(irq_o), int'(m_irq));
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input string req);
    cycle(1'b1, a, d, 1'b0, req);
  endtask

  task automatic idle(input logic di, input string req);
    cycle(1'b0, 2'd0, '0, di, req);
  endtask

  task automatic t_reset;
    chk("R1", "state", int'(state_o), 0);
    chk("R1", "ser", int'(ser_o), 0);
    chk("R1", "cmp", int'(cmp_o), 0);
    chk("R1", "irq", int'(irq_o), 0);
    idle(1'b0, "R1");
    chk("R1", "stopped state", int'(state_o), 0);
  endtask

  task automatic t_seed_load;
    wr(2'd2, 8'hA5, "R7");
    chk("R7", "seed loaded", int'(state_o), 8'hA5);
    idle(1'b0, "R8");
    idle(1'b0, "R8");
    chk("R8", "held", int'(state_o), 8'hA5);
  endtask

  task automatic t_short_period;
    wr(2'd0, 8'h00, "R2");
    wr(2'd1, 8'h05, "R3");
    wr(2'd2, 8'h01, "R7");
    wr(2'd0, 8'h01, "R2");
    begin
      int first = 0;
      for (int i = 1; i <= 7; i++) begin
        idle(1'b0, "R4");
        if (first == 0 && state_o == 8'h01) first = i;
      end
      chk("R5", "period taps 05", first, 7);
    end
  endtask

  task automatic t_long_period;
    wr(2'd0, 8'h00, "R2");
    wr(2'd1, 8'h55, "R3");
    wr(2'd2, 8'h01, "R7");
    wr(2'd3, 8'h40, "R11");
    wr(2'd0, 8'h01, "R2");
    begin
      int first = 0;
      for (int i = 1; i <= 130; i++) begin
        idle(1'b0, "R4");
        if (first == 0 && state_o == 8'h01) first = i;
      end
      chk("R5", "period taps 55", first, 127);
    end
  endtask

  task automatic t_taps_locked;
    // running with 0x55 from previous scenario
    wr(2'd1, 8'h06, "R6");
    for (int i = 0; i < 10; i++) idle(1'b0, "R6");
    wr(2'd0, 8'h00, "R2");
    chk("R6", "ser still from len 7", int'(ser_o), int'(state_o[6]));
  endtask

  task automatic t_seed_locked;
    wr(2'd0, 8'h01, "R2");
    idle(1'b0, "R4");
    wr(2'd2, 8'hFF, "R7");
    chk("R7", "seed ignored while running", int'(state_o != 8'hFF), 1);
    idle(1'b0, "R7");
  endtask

  task automatic t_upper_clear;
    wr(2'd0, 8'h00, "R2");
    wr(2'd1, 8'h05, "R3");
    wr(2'd2, 8'hF9, "R7");
    wr(2'd0, 8'h01, "R2");
    idle(1'b0, "R4");
    chk("R4", "upper bits cleared", int'(state_o), 8'h02);
  endtask

  task automatic t_crc_input;
    logic [15:0] pat = 16'hB3C5;
    wr(2'd0, 8'h00, "R2");
    wr(2'd1, 8'h55, "R3");
    wr(2'd2, 8'h00, "R7");
    wr(2'd0, 8'h01, "R2");
    for (int i = 0; i < 16; i++) idle(pat[i], "R4");
  endtask

  task automatic t_zero_lock;
    wr(2'd0, 8'h00, "R2");
    wr(2'd2, 8'h00, "R7");
    wr(2'd0, 8'h01, "R2");
    for (int i = 0; i < 6; i++) idle(1'b0, "R9");
    chk("R9", "zero stays", int'(state_o), 0);
  endtask

  task automatic t_no_taps;
    wr(2'd0, 8'h00, "R2");
    wr(2'd1, 8'h00, "R3");
    wr(2'd2, 8'h5A, "R7");
    wr(2'd0, 8'h01, "R2");
    for (int i = 0; i < 4; i++) idle(1'b1, "R3");
    chk("R3", "zero taps hold", int'(state_o), 8'h5A);
    chk("R10", "ser zero taps", int'(ser_o), 0);
  endtask

  task automatic t_compare;
    wr(2'd0, 8'h00, "R2");
    wr(2'd1, 8'h55, "R3");
    wr(2'd2, 8'h10, "R7");
    wr(2'd3, 8'h11, "R11");
    chk("R11", "below limit", int'(cmp_o), 0);
    wr(2'd3, 8'h10, "R11");
    chk("R11", "equal limit", int'(cmp_o), 1);
    chk("R12", "pulse on rise", int'(irq_o), 1);
    idle(1'b0, "R12");
    chk("R12", "pulse one cycle", int'(irq_o), 0);
    wr(2'd3, 8'h20, "R11");
    wr(2'd0, 8'h01, "R2");
    for (int i = 0; i < 40; i++) idle(1'b0, "R11");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_seed_load();
    t_short_period();
    t_long_period();
    t_taps_locked();
    t_seed_locked();
    t_upper_clear();
    t_crc_input();
    t_zero_lock();
    t_no_taps();
    t_compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule